// File: doc/BRIEF.md
# SPI Port Controller (master or slave, byte exchange)

This block is a byte-wide serial port that a processor drives through three small registers: a control register, a status register and a data register. In master mode it generates the serial clock itself from the system clock. Writing a byte into the data register starts an eight-bit exchange. During the exchange the byte leaves on the MOSI line while a byte from the far side arrives on MISO. When the last bit is in, the received byte replaces the sent one in the data register.

In slave mode the block takes the serial clock from outside. It takes part in an exchange only while its active-low select input is low. It drives MISO only during that time and leaves the line in high impedance otherwise. All external inputs in slave mode pass through a two-flop synchronizer. On either side, a sticky completion flag marks the end of a byte and can raise an interrupt. A separate flag records a data write that arrived while an exchange was running. Such a write is discarded.

Top module: `spi_port`

## Requirements
- R1: After reset, the control register (address 0) and the status register (address 1) read zero, `irq` is low, and `sck_oe`, `mosi_oe` and `miso_oe` are low.
- R2: In master mode (control bit 0 enable = 1, bit 1 master = 1), a write to the data register (address 2) while idle starts an exchange. SCK idles low and produces exactly eight high pulses, then stays low.
- R3: Control bits 5:4 set the SCK half period in system clocks: 00 gives 2, 01 gives 8, 10 gives 32 and 11 gives 64. These correspond to division by 4, 16, 64 and 128. The first rising edge comes one half period after the write is taken.
- R4: Control bit 2 set to 1 sends the least significant bit first, and 0 sends the most significant bit first. The outgoing bit changes only on falling SCK edges.
- R5: The incoming line is sampled on each rising SCK edge, in the same bit order as the outgoing line. When the exchange ends, the data register reads the received byte.
- R6: After the eighth falling edge, status bit 0 (done) is set. `irq` equals done AND control bit 3 (interrupt enable).
- R7: A data write during an exchange is discarded: the bits on the line and the received byte are unaffected. Status bit 1 (collision) is set.
- R8: A status read while a flag is set, followed by a data-register access, clears both status bits. Until then, done stays set.
- R9: In slave mode (enable = 1, master = 0), SCK and MOSI are synchronized. The slave drives MISO (`miso_oe` = 1) only while `ss_n` is low, shifting out the preloaded byte in the selected order while capturing MOSI. It sets done after eight bits.
- R10: If `ss_n` rises part-way through a byte, the bit counter returns to zero, `miso_oe` drops, and done is not set. A following full byte is received correctly.
- R11: `sck_oe` and `mosi_oe` are high only in master mode. `sck_oe` stays low in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe (read side effects) |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data for `cpu_addr` |
| irq | output | 1 | Interrupt request |
| sck_in | input | 1 | Serial clock from a master (slave mode) |
| sck_out | output | 1 | Generated serial clock (master mode) |
| sck_oe | output | 1 | Output enable for `sck_out` |
| mosi_in | input | 1 | Serial data from a master (slave mode) |
| mosi_out | output | 1 | Serial data to a slave (master mode) |
| mosi_oe | output | 1 | Output enable for `mosi_out` |
| miso_in | input | 1 | Serial data from a slave (master mode) |
| miso_out | output | 1 | Serial data to a master (slave mode) |
| miso_oe | output | 1 | Output enable for `miso_out` |
| ss_n | input | 1 | Active-low slave select (slave mode) |

## Verification
A divider count that goes wrong moves the SCK edges on the pin within one half period. A bench that compares SCK and MOSI on every clock catches this in the first bit of the byte. A bad shift direction or bit counter shows as a wrong MOSI value at the next falling edge. It also shows as a wrong byte read back, or a missing or early done flag, right after the eighth pulse. Flag handling errors show on the status register and `irq` within the few reads that follow a byte. A slave that fails to reset on deselect shows as a wrong byte on the next full exchange.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int ADDR_W   = 2;
  localparam int HALF_MAX = 64;
  localparam int HALF_W   = $clog2(HALF_MAX + 1);

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic [1:0] rate;
    logic       irq_en;
    logic       lsb_first;
    logic       master;
    logic       enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // SCK half period in system clocks for each rate code
  function automatic logic [HALF_W-1:0] half_of(input logic [1:0] rate);
    case (rate)
      2'd0:    half_of = HALF_W'(2);
      2'd1:    half_of = HALF_W'(8);
      2'd2:    half_of = HALF_W'(32);
      default: half_of = HALF_W'(HALF_MAX);
    endcase
  endfunction
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/spi_port_clkdiv.sv
module spi_port_clkdiv #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [CW-1:0] half,
  output logic          tick
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == half - CW'(1));
  assign tick = run & wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !run) cnt_d = '0;
    else if (wrap)       cnt_d = '0;
    else                 cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: half period is at least two clocks, so edges never come back to back
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [DW-1:0]         load_data,
  input  logic                  lsb_first,
  input  logic                  sample_en,
  input  logic                  sample_bit,
  input  logic                  shift_en,
  input  logic                  cnt_clr,
  output logic [DW-1:0]         data,
  output logic                  out_bit,
  output logic                  last,
  output logic [$clog2(DW)-1:0] bit_cnt
);
  localparam int CNTW = $clog2(DW);

  logic [DW-1:0]   sreg_q, sreg_d;
  logic            in_q, in_d;
  logic [CNTW-1:0] cnt_q, cnt_d;

  assign data    = sreg_q;
  assign bit_cnt = cnt_q;
  assign out_bit = lsb_first ? sreg_q[0] : sreg_q[DW-1];
  assign last    = shift_en & (cnt_q == CNTW'(DW - 1));

  always_comb begin
    sreg_d = sreg_q;
    if (load)
      sreg_d = load_data;
    else if (shift_en)
      sreg_d = lsb_first ? {in_q, sreg_q[DW-1:1]} : {sreg_q[DW-2:0], in_q};
  end

  always_comb begin
    in_d = sample_en ? sample_bit : in_q;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_clr || last) cnt_d = '0;
    else if (shift_en)   cnt_d = cnt_q + CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      in_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sreg_q <= sreg_d;
      in_q   <= in_d;
      cnt_q  <= cnt_d;
    end
  end

  // R5: the bit captured on the rising edge enters the register on the falling edge
  p_capture_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load && !lsb_first) |=> (sreg_q[0] == $past(in_q)));
  p_capture_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load && lsb_first) |=> (sreg_q[DW-1] == $past(in_q)));
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              irq,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              mosi_in,
  output logic              mosi_out,
  output logic              mosi_oe,
  input  logic              miso_in,
  output logic              miso_out,
  output logic              miso_oe,
  input  logic              ss_n
);
  localparam int CNTW = $clog2(DW);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i = rst_pipe_q[1];

  // slave-side inputs through two flops
  logic ss_s, sck_s, mosi_s;
  spi_port_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_i),
    .d({ss_n, sck_in, mosi_in}),
    .q({ss_s, sck_s, mosi_s})
  );

  ctrl_t ctrl_q, ctrl_d;
  logic  busy_q, busy_d, sck_q, sck_d, sck_p_q;
  logic  spif_q, spif_d, wcol_q, wcol_d, armed_q, armed_d;

  logic m_mode, s_sel, tick, m_rise, m_fall, s_rise, s_fall;
  logic dwr, daccess, sread, load, coll, flag_clr, cnt_clr;
  logic sh_out, sh_last;
  logic [DW-1:0]   sh_data;
  logic [CNTW-1:0] sh_cnt;

  assign m_mode   = ctrl_q.enable & ctrl_q.master;
  assign s_sel    = ctrl_q.enable & ~ctrl_q.master & ~ss_s;
  assign m_rise   = tick & ~sck_q;
  assign m_fall   = tick & sck_q;
  assign s_rise   = s_sel & sck_s & ~sck_p_q;
  assign s_fall   = s_sel & ~sck_s & sck_p_q;

  assign dwr      = cpu_we & (cpu_addr == A_DATA);
  assign daccess  = (cpu_we | cpu_re) & (cpu_addr == A_DATA);
  assign sread    = cpu_re & (cpu_addr == A_STAT);
  assign load     = dwr & ~busy_q;
  assign coll     = dwr & busy_q;
  assign flag_clr = daccess & armed_q;
  assign cnt_clr  = load | ~(m_mode | s_sel);

  spi_port_clkdiv #(.CW(HALF_W)) u_div (
    .clk(clk), .rst_n(rst_i),
    .run(busy_q & m_mode), .restart(load),
    .half(half_of(ctrl_q.rate)), .tick(tick)
  );

  spi_port_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_i),
    .load(load), .load_data(cpu_wdata),
    .lsb_first(ctrl_q.lsb_first),
    .sample_en(m_rise | s_rise),
    .sample_bit(m_mode ? miso_in : mosi_s),
    .shift_en(m_fall | s_fall),
    .cnt_clr(cnt_clr),
    .data(sh_data), .out_bit(sh_out), .last(sh_last), .bit_cnt(sh_cnt)
  );

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (cpu_we && cpu_addr == A_CTRL) ctrl_d = ctrl_t'(cpu_wdata[CTRL_W-1:0]);

    busy_d = busy_q;
    if (m_mode) begin
      if (load)         busy_d = 1'b1;
      else if (sh_last) busy_d = 1'b0;
    end else if (s_sel) begin
      if (sh_last)      busy_d = 1'b0;
      else if (s_rise)  busy_d = 1'b1;
    end else begin
      busy_d = 1'b0;
    end

    sck_d = sck_q;
    if (!m_mode || load)     sck_d = 1'b0;
    else if (m_rise||m_fall) sck_d = ~sck_q;

    spif_d = spif_q;
    if (sh_last)       spif_d = 1'b1;
    else if (flag_clr) spif_d = 1'b0;

    wcol_d = wcol_q;
    if (coll)          wcol_d = 1'b1;
    else if (flag_clr) wcol_d = 1'b0;

    armed_d = armed_q;
    if (flag_clr)                      armed_d = 1'b0;
    else if (sread && (spif_q|wcol_q)) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q  <= '0;
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      sck_p_q <= 1'b0;
      spif_q  <= 1'b0;
      wcol_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      busy_q  <= busy_d;
      sck_q   <= sck_d;
      sck_p_q <= sck_s;
      spif_q  <= spif_d;
      wcol_q  <= wcol_d;
      armed_q <= armed_d;
    end
  end

  // outputs
  assign irq      = ctrl_q.irq_en & spif_q;
  assign sck_out  = sck_q;
  assign sck_oe   = m_mode;
  assign mosi_out = sh_out;
  assign mosi_oe  = m_mode;
  assign miso_out = sh_out;
  assign miso_oe  = s_sel;

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      A_CTRL:  cpu_rdata[CTRL_W-1:0] = ctrl_q;
      A_STAT:  cpu_rdata[1:0]        = {wcol_q, spif_q};
      A_DATA:  cpu_rdata             = sh_data;
      default: cpu_rdata             = '0;
    endcase
  end

  // R2: the done flag appears only once the exchange has stopped
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(spif_q) |-> !busy_q);
  // R2: master SCK rests low whenever no exchange runs
  p_sck_rest_r2: assert property (@(posedge clk) disable iff (!rst_i)
    (m_mode && !busy_q) |-> !sck_q);
  // R7: a colliding write does not stop the exchange in flight
  p_coll_keep_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (m_mode && coll && !sh_last) |=> busy_q);
  // R8: done holds until the clear sequence completes
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (spif_q && !flag_clr) |=> spif_q);
  // R10: deselecting a slave returns the bit counter to zero
  p_desel_cnt_r10: assert property (@(posedge clk) disable iff (!rst_i)
    (!m_mode && !s_sel) |=> (sh_cnt == '0));
endmodule

// File: tb/sim_spi_port.sv
`timescale 1ns/1ps
module sim_spi_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cpu_addr;
  logic       cpu_we, cpu_re;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic       irq, sck_in, sck_out, sck_oe, mosi_in, mosi_out, mosi_oe;
  logic       miso_in, miso_out, miso_oe, ss_n;

  always #2 clk = ~clk;

  spi_port #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
    .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
    .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe), .ss_n(ss_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cpu_addr = a; cpu_re = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_re = 1'b0;
  endtask

  // master exchange; the bench plays the slave and tracks every cycle
  task automatic mxfer(input logic [7:0] tx, input logic [7:0] rx, input logic [1:0] rate,
                       input bit lsb, input bit ien, input bit collide);
    int h;
    logic [7:0] v;
    case (rate)
      2'd0: h = 2;
      2'd1: h = 8;
      2'd2: h = 32;
      default: h = 64;
    endcase
    wr(2'd0, {2'b00, rate, ien, lsb, 1'b1, 1'b1});
    chk("R11 sck_oe master", sck_oe, 1);
    chk("R11 mosi_oe master", mosi_oe, 1);
    chk("R2 sck idle", sck_out, 0);
    cpu_addr = 2'd2; cpu_wdata = tx; cpu_we = 1'b1;
    @(negedge clk);
    for (int t = 0; t < 16 * h; t++) begin
      int k = t / (2 * h);
      cpu_we  = 1'b0;
      miso_in = lsb ? rx[k] : rx[7-k];
      chk("R3 sck timing", sck_out, (t / h) % 2);
      chk("R4 mosi bit", mosi_out, lsb ? tx[k] : tx[7-k]);
      if (collide && t == 3 * h) begin
        cpu_addr = 2'd2; cpu_wdata = ~tx; cpu_we = 1'b1;
      end
      @(negedge clk);
    end
    cpu_we = 1'b0;
    chk("R2 sck stopped", sck_out, 0);
    chk("R6 irq", irq, ien);
    cyc(3);
    chk("R2 no extra pulse", sck_out, 0);
    rd(2'd1, v);
    chk("R6 done flag", v[0], 1);
    chk("R7 collision flag", v[1], collide);
    rd(2'd2, v);
    chk("R5 received byte", v, rx);
    rd(2'd1, v);
    chk("R8 flags cleared", v, 0);
    chk("R8 irq cleared", irq, 0);
  endtask

  // slave exchange; the bench plays the master
  task automatic sxfer(input logic [7:0] mtx, input logic [7:0] stx, input bit lsb, input int nbits);
    logic [7:0] v;
    wr(2'd0, {4'b0000, lsb, 1'b0, 1'b1});
    chk("R11 sck_oe slave", sck_oe, 0);
    wr(2'd2, stx);
    chk("R9 miso released", miso_oe, 0);
    ss_n = 1'b0;
    cyc(6);
    chk("R9 miso driven", miso_oe, 1);
    for (int k = 0; k < nbits; k++) begin
      mosi_in = lsb ? mtx[k] : mtx[7-k];
      cyc(4);
      chk("R9 miso bit", miso_out, lsb ? stx[k] : stx[7-k]);
      sck_in = 1'b1;
      cyc(8);
      sck_in = 1'b0;
      cyc(4);
    end
    cyc(4);
    ss_n = 1'b1;
    cyc(4);
    chk(nbits == 8 ? "R9 miso off" : "R10 miso off", miso_oe, 0);
    rd(2'd1, v);
    if (nbits == 8) begin
      chk("R9 slave done", v[0], 1);
      rd(2'd2, v);
      chk("R9 slave received", v, mtx);
      rd(2'd1, v);
      chk("R8 slave clear", v, 0);
    end else begin
      chk("R10 no done on abort", v[0], 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; cpu_addr = '0; cpu_we = 1'b0; cpu_re = 1'b0; cpu_wdata = '0;
    sck_in = 1'b0; mosi_in = 1'b0; miso_in = 1'b0; ss_n = 1'b1;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl reset", v, 0);
    rd(2'd1, v); chk("R1 status reset", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sck_oe", sck_oe, 0);
    chk("R1 mosi_oe", mosi_oe, 0);
    chk("R1 miso_oe", miso_oe, 0);

    mxfer(8'hA5, 8'h3C, 2'd0, 1'b0, 1'b0, 1'b0);
    mxfer(8'h81, 8'h7E, 2'd1, 1'b1, 1'b1, 1'b0);
    mxfer(8'hC3, 8'h96, 2'd2, 1'b0, 1'b1, 1'b1);
    mxfer(8'h0F, 8'hF0, 2'd3, 1'b1, 1'b0, 1'b1);
    mxfer(8'h00, 8'hFF, 2'd0, 1'b1, 1'b1, 1'b0);

    sxfer(8'hA6, 8'h59, 1'b0, 8);
    sxfer(8'h33, 8'hCA, 1'b1, 8);
    sxfer(8'h5D, 8'hB2, 1'b0, 3);
    sxfer(8'hE1, 8'h1E, 1'b0, 8);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule